// File: doc/BRIEF.md
# I2C EEPROM Target Protocol Engine

This block is the serial front end of an 8K x 8 byte-addressed memory that sits on a two-wire bus as a target. The raw clock and data lines are brought into the system clock domain through synchronizers. The engine then recognises Start and Stop conditions and shifts bytes in and out most significant bit first. It answers each byte in the ninth clock by pulling the data line low through an open-drain enable, or by leaving it released.

A transfer begins with a device address byte that holds a fixed type code, three strap bits and a direction bit. In the write direction, two word address bytes load a shared address pointer. Any data bytes that follow are passed one per pulse, together with their addresses, to a neighbouring write-buffer block. A Stop that ends a transfer carrying data asks that block to start its internal write cycle. In the read direction, bytes are fetched from a synchronous read port at the pointer. This serves current-address reads, random reads (a write-direction address phase followed by a repeated Start) and sequential reads. While the neighbour reports that a write cycle is still running, the device address is refused, so a host can poll for completion.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, and whenever the engine is idle, `sda_oe` is 0. No `wr_valid`, `wr_commit` or `rd_en` pulse is issued out of reset.
- R2: A device address byte is accepted and ACKed (SDA held low during the ninth clock) when bits 7..4 are 1010, bits 3..1 equal `strap[2:0]`, and `wr_busy` is low. Bit 0 selects read when 1 and write when 0.
- R3: A device address byte with a wrong type code or wrong strap bits is NACKed. Every later byte up to the next Start is also left unacknowledged and has no effect.
- R4: In the write direction, the first word address byte supplies address bits 12..8 from its bits 4..0, and its bits 7..5 are ignored. The second byte supplies bits 7..0. Each following data byte is ACKed and issued as a one-cycle `wr_valid` pulse with `wr_addr`/`wr_data`. The address then advances by one, wrapping from 8191 to 0.
- R5: A Stop that ends a write transfer in which at least one data byte completed gives exactly one `wr_commit` pulse. A Stop after an address-only phase gives none.
- R6: While `wr_busy` is high, a device address byte that otherwise matches is NACKed.
- R7: A current-address read returns the byte at the last accessed address plus one.
- R8: A random read (device address with write, two word address bytes, repeated Start, device address with read) returns the byte at the given address and issues no `wr_commit`.
- R9: In a read, a master ACK in the ninth clock makes the engine send the byte at the next address, wrapping from 8191 to 0. A master NACK ends the read with `sda_oe` released.
- R10: A Start or Stop in the middle of a byte abandons that byte. A partial data byte issues no `wr_valid`, and a Start restarts device address reception.
- R11: `sda_oe` changes only while SCL is low. It changes a few system cycles after the SCL falling edge, and never while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line (wired value of the bus) |
| strap | input | 3 | Hard-wired device address strap bits |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_busy | input | 1 | Write-buffer block is running an internal write cycle |
| wr_valid | output | 1 | One-cycle pulse: a data byte was received |
| wr_addr | output | 13 | Word address of the received data byte |
| wr_data | output | 8 | Received data byte |
| wr_commit | output | 1 | One-cycle pulse: start the internal write cycle |
| rd_en | output | 1 | Read port request |
| rd_addr | output | 13 | Read port address |
| rd_data | input | 8 | Read port data, valid one cycle after `rd_en` |

## Verification
The checks assume that every SCL high and low phase spans several system clocks. They also assume the host moves SDA only while SCL is low, except when it forms a Start or Stop, and never forms a Start or Stop while the engine holds SDA low. A further assumption is that `rd_data` answers one cycle after `rd_en`. The stimulus drives every bus bit through one task with a fixed quarter period of six system clocks. It raises a Start or Stop only after the engine has released the line, and models the read port as a registered array. Random write-then-read traffic is mixed with directed cases: strap and type mismatches, busy polling, address wrap, and Stop or Start placed inside a byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;
    localparam int         STRAP_BITS    = 3;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_WAIT,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_MACK_WAIT
    } tgt_state_e;

    typedef enum logic [1:0] {
        ROLE_DEV,
        ROLE_AHI,
        ROLE_ALO,
        ROLE_DATA
    } byte_role_e;

    function automatic logic dev_match(input logic [7:0] b,
                                       input logic [STRAP_BITS-1:0] s);
        return (b[7:4] == DEV_TYPE_CODE) && (b[3:1] == s);
    endfunction

    function automatic byte_role_e next_role(input byte_role_e r);
        case (r)
            ROLE_DEV: return ROLE_AHI;
            ROLE_AHI: return ROLE_ALO;
            default:  return ROLE_DATA;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_raw,
    input  logic     sda_raw,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_raw;
                    sda_ff <= sda_raw;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_raw};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_raw};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        evt.scl_rise = scl_s & ~scl_d;
        evt.scl_fall = ~scl_s & scl_d;
        evt.start    = scl_s & scl_d & sda_d & ~sda_s;
        evt.stop     = scl_s & scl_d & ~sda_d & sda_s;
        evt.sda      = sda_s;
    end

endmodule

// File: rtl/i2c_word_ptr.sv
module i2c_word_ptr #(
    parameter int ADDR_W = 13,
    parameter int DEPTH  = 8192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] ptr
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_inc;

    generate
        if (DEPTH == (1 << ADDR_W)) begin : g_pow2
            assign ptr_inc = ptr_q + ADDR_W'(1);
        end else begin : g_limit
            assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + ADDR_W'(1);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_val;
        end else if (inc) begin
            ptr_q <= ptr_inc;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic                  clk,
    input  logic                  rst,
    input  bus_evt_t              evt,
    input  logic [STRAP_BITS-1:0] strap,
    input  logic                  wr_busy,
    input  logic [7:0]            rd_data,
    output logic                  sda_drive,
    output logic                  rd_req,
    output logic                  wr_valid,
    output logic [7:0]            wr_data,
    output logic                  wr_commit,
    output logic                  ptr_load,
    output logic [ADDR_W-1:0]     ptr_val
);

    localparam int HI_W = ADDR_W - 8;

    tgt_state_e        state_q;
    byte_role_e        role_q;
    logic [2:0]        bit_q;
    logic [7:0]        rx_q;
    logic [7:0]        tx_q;
    logic [7:0]        txbuf_q;
    logic [HI_W-1:0]   hi_q;
    logic              ack_q;
    logic              rnw_q;
    logic              wr_any_q;
    logic              cap_q;
    logic              rd_req_q;
    logic              wr_valid_q;
    logic [7:0]        wr_data_q;
    logic              wr_commit_q;
    logic              ptr_load_q;
    logic [ADDR_W-1:0] ptr_val_q;
    logic [7:0]        rx_nxt;

    assign rx_nxt = {rx_q[6:0], evt.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            role_q      <= ROLE_DEV;
            bit_q       <= '0;
            rx_q        <= '0;
            tx_q        <= '1;
            txbuf_q     <= '0;
            hi_q        <= '0;
            ack_q       <= 1'b0;
            rnw_q       <= 1'b0;
            wr_any_q    <= 1'b0;
            cap_q       <= 1'b0;
            rd_req_q    <= 1'b0;
            wr_valid_q  <= 1'b0;
            wr_data_q   <= '0;
            wr_commit_q <= 1'b0;
            ptr_load_q  <= 1'b0;
            ptr_val_q   <= '0;
        end else begin
            rd_req_q    <= 1'b0;
            wr_valid_q  <= 1'b0;
            wr_commit_q <= 1'b0;
            ptr_load_q  <= 1'b0;
            cap_q       <= rd_req_q;
            if (cap_q) begin
                txbuf_q <= rd_data;
            end

            if (evt.stop) begin
                state_q     <= ST_IDLE;
                wr_commit_q <= wr_any_q;
                wr_any_q    <= 1'b0;
            end else if (evt.start) begin
                state_q  <= ST_RX;
                role_q   <= ROLE_DEV;
                bit_q    <= '0;
                wr_any_q <= 1'b0;
            end else begin
                case (state_q)
                    ST_RX: begin
                        if (evt.scl_rise) begin
                            rx_q  <= rx_nxt;
                            bit_q <= bit_q + 3'd1;
                            if (bit_q == 3'd7) begin
                                state_q <= ST_ACK_WAIT;
                                bit_q   <= '0;
                                case (role_q)
                                    ROLE_DEV: begin
                                        ack_q <= dev_match(rx_nxt, strap) && !wr_busy;
                                        rnw_q <= rx_nxt[0];
                                    end
                                    ROLE_AHI: begin
                                        hi_q  <= rx_nxt[HI_W-1:0];
                                        ack_q <= 1'b1;
                                    end
                                    ROLE_ALO: begin
                                        ptr_load_q <= 1'b1;
                                        ptr_val_q  <= {hi_q, rx_nxt};
                                        ack_q      <= 1'b1;
                                    end
                                    default: begin
                                        wr_valid_q <= 1'b1;
                                        wr_data_q  <= rx_nxt;
                                        wr_any_q   <= 1'b1;
                                        ack_q      <= 1'b1;
                                    end
                                endcase
                            end
                        end
                    end
                    ST_ACK_WAIT: begin
                        if (evt.scl_fall) begin
                            if (ack_q) begin
                                state_q <= ST_ACK;
                                if (role_q == ROLE_DEV && rnw_q) begin
                                    rd_req_q <= 1'b1;
                                end
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (evt.scl_fall) begin
                            if (role_q == ROLE_DEV && rnw_q) begin
                                state_q <= ST_TX;
                                tx_q    <= txbuf_q;
                                bit_q   <= '0;
                            end else begin
                                state_q <= ST_RX;
                                role_q  <= next_role(role_q);
                                bit_q   <= '0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_fall) begin
                            if (bit_q == 3'd7) begin
                                state_q <= ST_MACK;
                                bit_q   <= '0;
                            end else begin
                                tx_q  <= {tx_q[6:0], 1'b1};
                                bit_q <= bit_q + 3'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (evt.scl_rise) begin
                            if (!evt.sda) begin
                                rd_req_q <= 1'b1;
                                state_q  <= ST_MACK_WAIT;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    ST_MACK_WAIT: begin
                        if (evt.scl_fall) begin
                            state_q <= ST_TX;
                            tx_q    <= txbuf_q;
                            bit_q   <= '0;
                        end
                    end
                    default: begin
                        state_q <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    assign sda_drive = (state_q == ST_ACK) || (state_q == ST_TX && !tx_q[7]);
    assign rd_req    = rd_req_q;
    assign wr_valid  = wr_valid_q;
    assign wr_data   = wr_data_q;
    assign wr_commit = wr_commit_q;
    assign ptr_load  = ptr_load_q;
    assign ptr_val   = ptr_val_q;

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import i2c_tgt_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int DEPTH       = 1 << ADDR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        strap,
    output logic              sda_oe,
    input  logic              wr_busy,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data
);

    bus_evt_t          evt;
    logic              ptr_load;
    logic [ADDR_W-1:0] ptr_val;
    logic [ADDR_W-1:0] ptr;
    logic              rd_req;
    logic              wr_pulse;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .evt     (evt)
    );

    i2c_tgt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .strap     (strap),
        .wr_busy   (wr_busy),
        .rd_data   (rd_data),
        .sda_drive (sda_oe),
        .rd_req    (rd_req),
        .wr_valid  (wr_pulse),
        .wr_data   (wr_data),
        .wr_commit (wr_commit),
        .ptr_load  (ptr_load),
        .ptr_val   (ptr_val)
    );

    i2c_word_ptr #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (ptr_val),
        .inc      (rd_req | wr_pulse),
        .ptr      (ptr)
    );

    assign wr_valid = wr_pulse;
    assign wr_addr  = ptr;
    assign rd_en    = rd_req;
    assign rd_addr  = ptr;

endmodule

// File: rtl/i2c_eeprom_target_chk.sv
module i2c_eeprom_target_chk (
    input logic clk,
    input logic rst,
    input logic scl_in,
    input logic sda_oe,
    input logic wr_valid,
    input logic wr_commit,
    input logic rd_en
);

    a_r1_released_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sda_oe && !wr_valid && !wr_commit && !rd_en);

    a_r11_sda_steady_scl_high: assert property (@(posedge clk) disable iff (rst)
        (scl_in && $past(scl_in)) |-> $stable(sda_oe));

    a_r4_wr_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    a_r5_commit_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_commit |=> !wr_commit);

    a_r9_fetch_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en);

    a_r4_no_fetch_during_write: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_valid));

endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_oe    (sda_oe),
    .wr_valid  (wr_valid),
    .wr_commit (wr_commit),
    .rd_en     (rd_en)
);

// File: tb/sim_i2c_eeprom_target.sv
`timescale 1ns/1ps
module sim_i2c_eeprom_target;

    localparam int         Q      = 6;
    localparam int         NWORDS = 8192;
    localparam logic [2:0] STRAP  = 3'b101;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic        sda_line;
    logic        wr_busy = 1'b0;
    logic        wr_valid;
    logic [12:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_commit;
    logic        rd_en;
    logic [12:0] rd_addr;
    logic [7:0]  rd_data = 8'h00;

    logic [7:0]  mem     [0:NWORDS-1];
    logic [7:0]  exp_mem [0:NWORDS-1];
    logic [12:0] wlog_a  [0:255];
    logic [7:0]  wlog_d  [0:255];
    logic [7:0]  wbuf    [0:7];
    logic [7:0]  rbuf    [0:7];
    int          wr_cnt = 0;
    int          commit_cnt = 0;
    int          busy_cnt = 0;
    int          r11_viol = 0;
    logic        prev_scl = 1'b1;
    logic        prev_oe = 1'b0;
    int          n_tests = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_eeprom_target u0 (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .strap     (STRAP),
        .sda_oe    (sda_oe),
        .wr_busy   (wr_busy),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_commit (wr_commit),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 7) ^ (a >> 4) ^ 8'h5A);
    endfunction

    // Read port and write-buffer neighbour models
    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_valid) begin
                mem[wr_addr] = wr_data;
                wlog_a[wr_cnt % 256] = wr_addr;
                wlog_d[wr_cnt % 256] = wr_data;
                wr_cnt++;
            end
            if (wr_commit) begin
                commit_cnt++;
                busy_cnt = 300;
            end else if (busy_cnt > 0) begin
                busy_cnt--;
            end
            wr_busy = (busy_cnt != 0);
            if (scl_m && prev_scl && (sda_oe !== prev_oe)) r11_viol++;
        end
        prev_scl = scl_m;
        prev_oe  = sda_oe;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        tick(Q); sda_m = b; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0;
    endtask

    task automatic bit_in(output logic b);
        tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_line; tick(Q); scl_m = 1'b0;
    endtask

    task automatic i2c_start();
        tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0;
    endtask

    task automatic i2c_stop();
        tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_in(s);
            b[i] = s;
        end
        bit_out(~master_ack);
    endtask

    task automatic wait_idle();
        while (wr_busy) tick(1);
        tick(4);
    endtask

    task automatic do_write(input logic [12:0] a, input int n);
        logic ack;
        int   base;
        base = wr_cnt;
        i2c_start();
        send_byte({4'hA, STRAP, 1'b0}, ack); chk("R2 device address ACK (write)", ack, 1);
        send_byte({3'($urandom), a[12:8]}, ack); chk("R4 high word address ACK", ack, 1);
        send_byte(a[7:0], ack); chk("R4 low word address ACK", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack); chk("R4 data ACK", ack, 1);
            exp_mem[(int'(a) + i) % NWORDS] = wbuf[i];
        end
        i2c_stop();
        tick(4);
        chk("R4 data handoff count", wr_cnt - base, n);
        for (int i = 0; i < n; i++) begin
            chk("R4 handoff address", wlog_a[(base + i) % 256], (int'(a) + i) % NWORDS);
            chk("R4 handoff data", wlog_d[(base + i) % 256], wbuf[i]);
        end
    endtask

    task automatic do_rand_read(input logic [12:0] a, input int n);
        logic       ack;
        logic [7:0] b;
        i2c_start();
        send_byte({4'hA, STRAP, 1'b0}, ack); chk("R8 dummy write device ACK", ack, 1);
        send_byte({3'b000, a[12:8]}, ack); chk("R8 high address ACK", ack, 1);
        send_byte(a[7:0], ack); chk("R8 low address ACK", ack, 1);
        i2c_start();
        send_byte({4'hA, STRAP, 1'b1}, ack); chk("R2 device address ACK (read)", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            rbuf[i] = b;
        end
        i2c_stop();
        tick(4);
    endtask

    initial begin
        logic        ack;
        logic [7:0]  b;
        int          c0;
        int          w0;
        logic [12:0] ra;
        int          len;

        void'($urandom(32'd20240611));
        for (int a = 0; a < NWORDS; a++) begin
            mem[a]     = init_val(a);
            exp_mem[a] = init_val(a);
        end
        tick(5);
        rst = 1'b0;
        tick(2);
        chk("R1 sda_oe after reset", sda_oe, 0);
        chk("R1 no wr_valid after reset", wr_valid, 0);
        chk("R1 no rd_en after reset", rd_en, 0);

        // Write across the top of the array, junk in high-byte bits 7..5
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        c0 = commit_cnt;
        do_write(13'h1FFE, 3);
        chk("R5 one commit after data", commit_cnt - c0, 1);

        // Busy polling
        i2c_start();
        send_byte({4'hA, STRAP, 1'b0}, ack);
        chk("R6 NACK while busy", ack, 0);
        i2c_stop();
        wait_idle();
        c0 = commit_cnt;
        i2c_start();
        send_byte({4'hA, STRAP, 1'b0}, ack);
        chk("R2 ACK after busy ends", ack, 1);
        i2c_stop();
        tick(4);
        chk("R5 no commit without data", commit_cnt - c0, 0);

        // Mismatches
        w0 = wr_cnt;
        i2c_start();
        send_byte({4'hA, 3'b011, 1'b0}, ack);
        chk("R3 strap mismatch NACK", ack, 0);
        send_byte(8'h00, ack);
        chk("R3 later byte ignored", ack, 0);
        chk("R3 sda_oe released", sda_oe, 0);
        i2c_stop();
        i2c_start();
        send_byte({4'hB, STRAP, 1'b1}, ack);
        chk("R3 type mismatch NACK", ack, 0);
        i2c_stop();
        tick(4);
        chk("R3 no handoff after mismatch", wr_cnt - w0, 0);

        // Random read with sequential wrap
        c0 = commit_cnt;
        do_rand_read(13'h1FFE, 3);
        chk("R8 random read data", rbuf[0], exp_mem[13'h1FFE]);
        chk("R9 sequential next", rbuf[1], exp_mem[13'h1FFF]);
        chk("R9 wrap to 0", rbuf[2], exp_mem[0]);
        chk("R9 released after NACK", sda_oe, 0);
        chk("R8 no commit on random read", commit_cnt - c0, 0);

        // Current address read
        i2c_start();
        send_byte({4'hA, STRAP, 1'b1}, ack);
        chk("R7 device ACK", ack, 1);
        recv_byte(1'b0, b);
        i2c_stop();
        chk("R7 current address byte", b, exp_mem[1]);

        // Stop inside a data byte
        w0 = wr_cnt;
        c0 = commit_cnt;
        i2c_start();
        send_byte({4'hA, STRAP, 1'b0}, ack);
        send_byte(8'h01, ack);
        send_byte(8'h00, ack);
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
        i2c_stop();
        tick(4);
        chk("R10 partial byte not handed out", wr_cnt - w0, 0);
        chk("R10 no commit for partial byte", commit_cnt - c0, 0);
        i2c_start();
        send_byte({4'hA, STRAP, 1'b1}, ack);
        recv_byte(1'b0, b);
        i2c_stop();
        chk("R7 read at loaded address", b, exp_mem[13'h0100]);

        // Start inside a byte
        i2c_start();
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        i2c_start();
        send_byte({4'hA, STRAP, 1'b1}, ack);
        chk("R10 restart takes device address", ack, 1);
        recv_byte(1'b0, b);
        i2c_stop();
        chk("R7 read after restart", b, exp_mem[13'h0101]);

        // Random traffic
        for (int it = 0; it < 6; it++) begin
            ra  = 13'($urandom % NWORDS);
            len = 1 + int'($urandom % 4);
            for (int i = 0; i < len; i++) wbuf[i] = 8'($urandom);
            do_write(ra, len);
            wait_idle();
            do_rand_read(ra, len);
            for (int i = 0; i < len; i++)
                chk("R9 random readback", rbuf[i], exp_mem[(int'(ra) + i) % NWORDS]);
        end

        chk("R11 sda_oe steady while SCL high", r11_viol, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule